// File: doc/BRIEF.md
# Logical Device Configuration Register File

This block is the configuration register file of one logical device on an expansion card. The host first writes an 8-bit register index into an index port. It then reads or writes the selected register through a byte-wide data port. The stored settings describe the device's resources: up to four memory windows, up to eight I/O base addresses, two interrupt selections and two DMA channel selections.

Each register applies its own rules. Read-only bits ignore writes. Reserved bits read as zero. Registers that are not implemented return a defined value. A window of vendor-defined indices is backed by plain scratch storage. Every stored field is also driven onto parallel outputs, so that address, interrupt and DMA decoders elsewhere on the card can use it directly.

Parameters set how many memory windows, I/O bases and DMA selects are implemented, how many I/O address bits are stored, and the fixed decode-mode bit of the memory control registers. The defaults are 3 memory windows, 6 I/O bases, 1 DMA select, 10 I/O bits and decode mode 1.

Top module: `ldev_cfg_regs`

## Requirements
- R1: A rising clock edge with `idxWe` high latches `idxIn` as the current index. `dataOut` is combinational and always shows the register selected by the latched index.
- R2: A rising clock edge with `dataWe` high writes `dataIn` to the register selected by the index latched before that edge, even if `idxWe` is high on the same edge.
- R3: After reset, every writable register reads 0, except the DMA selects, which read 4. Index 0x42 reads 0x01 (decode-mode bit 1).
- R4: Memory window k (k = 0..3) lives at 0x40+8k. Offset +0 holds base[23:16], +1 base[15:8], +3 limit[23:16] and +4 limit[15:8]. Offsets +5..+7 read 0. Windows with k >= NUM_MEM (default 3) read 0 and ignore writes.
- R5: Memory control (offset +2) stores only bit 1, the 16-bit width flag, which drives `memWide[k]`. Bit 0 is read-only and equals the decode-mode parameter (default 1). Bits [7:2] read 0.
- R6: I/O base k lives at 0x60+2k, with the high byte at the even index and the low byte at the odd index. Bases with k >= NUM_IO (default 6) read 0 and ignore writes. Address bits at or above IO_BITS (default 10) are not stored and read 0.
- R7: Indices 0x70 and 0x72 hold interrupt levels in bits [3:0]. Indices 0x71 and 0x73 hold interrupt types in bits [1:0]. All upper bits read 0.
- R8: Indices 0x74 and 0x75 hold DMA channels in bits [2:0], and upper bits read 0. A select with number >= NUM_DMA (default 1, so 0x75 is absent) reads 4, ignores writes and drives 4 on `dmaChan`.
- R9: All indices not named in R4–R8 or R10 read 0, and writes to them change no stored field. This covers 0x00–0x3F, 0x76–0xEF and 0xFF.
- R10: Indices 0xF0–0xFE are scratch bytes that read back whatever was last written.
- R11: `memBase`, `memLimit`, `ioBase`, `irqLevel`, `irqType` and `dmaChan` carry slot k in field k. Each field is {high byte, low byte} where it has two bytes, and an absent slot drives 0 (4 for DMA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWe | input | 1 | Latch `idxIn` as current index |
| idxIn | input | 8 | Register index |
| dataWe | input | 1 | Write strobe for the selected register |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data of the selected register |
| memBase | output | 64 | Base[23:8] of memory windows 0..3, 16 bits each |
| memLimit | output | 64 | Limit/length[23:8] of memory windows 0..3 |
| memWide | output | 4 | 16-bit width flag per memory window |
| ioBase | output | 128 | I/O base of slots 0..7, 16 bits each |
| irqLevel | output | 8 | Interrupt level of selects 0..1, 4 bits each |
| irqType | output | 4 | Interrupt type of selects 0..1, 2 bits each |
| dmaChan | output | 6 | DMA channel of selects 0..1, 3 bits each |

## Verification
The assertions assume that the host drives `idxWe`, `dataWe`, `idxIn` and `dataIn` with known values on every edge after reset. They also assume the host releases reset only on a clock edge. The bench drives every input from tasks, one time unit after a rising edge, and holds both strobes low whenever no access is in progress. Every access, including the same-edge index-and-data case, therefore presents defined values to the edge that samples it.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;

  localparam int MAX_MEM   = 4;
  localparam int MAX_IO    = 8;
  localparam int IRQ_SLOTS = 2;
  localparam int MAX_DMA   = 2;
  // 16 entries keep the 4-bit offset in range; the decoder never selects 0xF
  localparam int VENDOR_DEPTH = 16;
  localparam logic [2:0] DMA_IDLE = 3'd4;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_MEM,
    CLS_IO,
    CLS_IRQ,
    CLS_DMA,
    CLS_DMA_ABSENT,
    CLS_VENDOR
  } regClass_e;

  typedef struct packed {
    logic      wr;
    regClass_e cls;
    logic [2:0] slot;
    logic [3:0] sub;
  } strobe_t;

endpackage

// File: rtl/ldev_cfg_ctrl.sv
module ldev_cfg_ctrl
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_MEM = 3,
  parameter int NUM_IO  = 6,
  parameter int NUM_DMA = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWe,
  input  logic [7:0] idxIn,
  input  logic       dataWe,
  output strobe_t    strobe
);

  logic [7:0] curIdx;

  always_ff @(posedge clk) begin
    if (!rstN)      curIdx <= 8'h00;
    else if (idxWe) curIdx <= idxIn;
  end

  always_comb begin
    strobe      = '0;
    strobe.cls  = CLS_NONE;
    strobe.wr   = dataWe;
    if (curIdx[7:5] == 3'b010) begin
      if ((int'(curIdx[4:3]) < NUM_MEM) && (curIdx[2:0] <= 3'd4)) begin
        strobe.cls  = CLS_MEM;
        strobe.slot = {1'b0, curIdx[4:3]};
        strobe.sub  = {1'b0, curIdx[2:0]};
      end
    end else if (curIdx[7:4] == 4'h6) begin
      if (int'(curIdx[3:1]) < NUM_IO) begin
        strobe.cls  = CLS_IO;
        strobe.slot = curIdx[3:1];
        strobe.sub  = {3'b000, curIdx[0]};
      end
    end else if (curIdx[7:2] == 6'b011100) begin
      strobe.cls  = CLS_IRQ;
      strobe.slot = {2'b00, curIdx[1]};
      strobe.sub  = {3'b000, curIdx[0]};
    end else if (curIdx[7:1] == 7'b0111010) begin
      strobe.slot = {2'b00, curIdx[0]};
      strobe.cls  = (int'(curIdx[0]) < NUM_DMA) ? CLS_DMA : CLS_DMA_ABSENT;
    end else if ((curIdx[7:4] == 4'hF) && (curIdx[3:0] != 4'hF)) begin
      strobe.cls = CLS_VENDOR;
      strobe.sub = curIdx[3:0];
    end
  end

  assert_idx_latch_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(idxWe)) |-> (curIdx == $past(idxIn)));

endmodule

// File: rtl/ldev_cfg_dp.sv
module ldev_cfg_dp
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_MEM    = 3,
  parameter int NUM_IO     = 6,
  parameter int NUM_DMA    = 1,
  parameter int IO_BITS    = 10,
  parameter bit LIMIT_MODE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [7:0]             dataIn,
  output logic [7:0]             dataOut,
  output logic [MAX_MEM*16-1:0]  memBase,
  output logic [MAX_MEM*16-1:0]  memLimit,
  output logic [MAX_MEM-1:0]     memWide,
  output logic [MAX_IO*16-1:0]   ioBase,
  output logic [IRQ_SLOTS*4-1:0] irqLevel,
  output logic [IRQ_SLOTS*2-1:0] irqType,
  output logic [MAX_DMA*3-1:0]   dmaChan
);

  localparam logic [15:0] IO_MASK = 16'((32'h1 << IO_BITS) - 1);
  localparam logic [MAX_IO*16-1:0] IO_OUT_MASK = {MAX_IO{IO_MASK}};

  logic [7:0] baseHi [NUM_MEM];
  logic [7:0] baseLo [NUM_MEM];
  logic [7:0] limHi  [NUM_MEM];
  logic [7:0] limLo  [NUM_MEM];
  logic       wideR  [NUM_MEM];
  logic [7:0] ioHi   [NUM_IO];
  logic [7:0] ioLo   [NUM_IO];
  logic [3:0] lvlR   [IRQ_SLOTS];
  logic [1:0] typR   [IRQ_SLOTS];
  logic [2:0] dmaR   [NUM_DMA];
  logic [7:0] scratch[VENDOR_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_MEM; k++) begin
        baseHi[k] <= '0; baseLo[k] <= '0; limHi[k] <= '0; limLo[k] <= '0; wideR[k] <= 1'b0;
      end
      for (int k = 0; k < NUM_IO; k++) begin
        ioHi[k] <= '0; ioLo[k] <= '0;
      end
      for (int k = 0; k < IRQ_SLOTS; k++) begin
        lvlR[k] <= '0; typR[k] <= '0;
      end
      for (int k = 0; k < NUM_DMA; k++) dmaR[k] <= DMA_IDLE;
      for (int k = 0; k < VENDOR_DEPTH; k++) scratch[k] <= '0;
    end else if (strobe.wr) begin
      case (strobe.cls)
        CLS_MEM: begin
          case (strobe.sub[2:0])
            3'd0: baseHi[strobe.slot[1:0]] <= dataIn;
            3'd1: baseLo[strobe.slot[1:0]] <= dataIn;
            3'd2: wideR[strobe.slot[1:0]]  <= dataIn[1];
            3'd3: limHi[strobe.slot[1:0]]  <= dataIn;
            3'd4: limLo[strobe.slot[1:0]]  <= dataIn;
            default: ;
          endcase
        end
        CLS_IO: begin
          if (strobe.sub[0]) ioLo[strobe.slot] <= dataIn & IO_MASK[7:0];
          else               ioHi[strobe.slot] <= dataIn & IO_MASK[15:8];
        end
        CLS_IRQ: begin
          if (strobe.sub[0]) typR[strobe.slot[0]] <= dataIn[1:0];
          else               lvlR[strobe.slot[0]] <= dataIn[3:0];
        end
        CLS_DMA:    dmaR[strobe.slot[0]] <= dataIn[2:0];
        CLS_VENDOR: scratch[strobe.sub]  <= dataIn;
        default: ;
      endcase
    end
  end

  always_comb begin
    dataOut = 8'h00;
    case (strobe.cls)
      CLS_MEM: begin
        case (strobe.sub[2:0])
          3'd0: dataOut = baseHi[strobe.slot[1:0]];
          3'd1: dataOut = baseLo[strobe.slot[1:0]];
          3'd2: dataOut = {6'b0, wideR[strobe.slot[1:0]], LIMIT_MODE};
          3'd3: dataOut = limHi[strobe.slot[1:0]];
          3'd4: dataOut = limLo[strobe.slot[1:0]];
          default: dataOut = 8'h00;
        endcase
      end
      CLS_IO:         dataOut = strobe.sub[0] ? ioLo[strobe.slot] : ioHi[strobe.slot];
      CLS_IRQ:        dataOut = strobe.sub[0] ? {6'b0, typR[strobe.slot[0]]}
                                              : {4'b0, lvlR[strobe.slot[0]]};
      CLS_DMA:        dataOut = {5'b0, dmaR[strobe.slot[0]]};
      CLS_DMA_ABSENT: dataOut = {5'b0, DMA_IDLE};
      CLS_VENDOR:     dataOut = scratch[strobe.sub];
      default:        dataOut = 8'h00;
    endcase
  end

  for (genvar k = 0; k < MAX_MEM; k++) begin : g_mem
    if (k < NUM_MEM) begin : g_on
      assign memBase[k*16 +: 16]  = {baseHi[k], baseLo[k]};
      assign memLimit[k*16 +: 16] = {limHi[k], limLo[k]};
      assign memWide[k]           = wideR[k];
    end else begin : g_off
      assign memBase[k*16 +: 16]  = '0;
      assign memLimit[k*16 +: 16] = '0;
      assign memWide[k]           = 1'b0;
    end
  end

  for (genvar k = 0; k < MAX_IO; k++) begin : g_io
    if (k < NUM_IO) begin : g_on
      assign ioBase[k*16 +: 16] = {ioHi[k], ioLo[k]};
    end else begin : g_off
      assign ioBase[k*16 +: 16] = '0;
    end
  end

  for (genvar k = 0; k < IRQ_SLOTS; k++) begin : g_irq
    assign irqLevel[k*4 +: 4] = lvlR[k];
    assign irqType[k*2 +: 2]  = typR[k];
  end

  for (genvar k = 0; k < MAX_DMA; k++) begin : g_dma
    if (k < NUM_DMA) begin : g_on
      assign dmaChan[k*3 +: 3] = dmaR[k];
    end else begin : g_off
      assign dmaChan[k*3 +: 3] = DMA_IDLE;
    end
  end

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr && (strobe.cls == CLS_NONE || strobe.cls == CLS_DMA_ABSENT)) |=>
      ($stable(memBase) && $stable(memLimit) && $stable(memWide) && $stable(ioBase)
       && $stable(irqLevel) && $stable(irqType) && $stable(dmaChan)));

  assert_dma_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cls == CLS_DMA || strobe.cls == CLS_DMA_ABSENT) |-> (dataOut[7:3] == 5'b0));

  assert_irq_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cls == CLS_IRQ) |-> (dataOut[7:4] == 4'b0));

  assert_mem_ctrl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cls == CLS_MEM && strobe.sub == 4'd2) |->
      (dataOut[7:2] == 6'b0 && dataOut[0] == LIMIT_MODE));

  assert_io_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((ioBase & ~IO_OUT_MASK) == '0));

endmodule

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_MEM    = 3,
  parameter int NUM_IO     = 6,
  parameter int NUM_DMA    = 1,
  parameter int IO_BITS    = 10,
  parameter bit LIMIT_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         idxWe,
  input  logic [7:0]   idxIn,
  input  logic         dataWe,
  input  logic [7:0]   dataIn,
  output logic [7:0]   dataOut,
  output logic [63:0]  memBase,
  output logic [63:0]  memLimit,
  output logic [3:0]   memWide,
  output logic [127:0] ioBase,
  output logic [7:0]   irqLevel,
  output logic [3:0]   irqType,
  output logic [5:0]   dmaChan
);

  strobe_t strobe;

  ldev_cfg_ctrl #(.NUM_MEM(NUM_MEM), .NUM_IO(NUM_IO), .NUM_DMA(NUM_DMA)) u_ctrl (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .idxIn(idxIn), .dataWe(dataWe), .strobe(strobe)
  );

  ldev_cfg_dp #(.NUM_MEM(NUM_MEM), .NUM_IO(NUM_IO), .NUM_DMA(NUM_DMA),
                .IO_BITS(IO_BITS), .LIMIT_MODE(LIMIT_MODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .dataOut(dataOut),
    .memBase(memBase), .memLimit(memLimit), .memWide(memWide), .ioBase(ioBase),
    .irqLevel(irqLevel), .irqType(irqType), .dmaChan(dmaChan)
  );

endmodule

// File: tb/ldev_cfg_regs_test.sv
module ldev_cfg_regs_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         idxWe = 1'b0;
  logic [7:0]   idxIn = 8'h00;
  logic         dataWe = 1'b0;
  logic [7:0]   dataIn = 8'h00;
  logic [7:0]   dataOut;
  logic [63:0]  memBase, memLimit;
  logic [3:0]   memWide;
  logic [127:0] ioBase;
  logic [7:0]   irqLevel;
  logic [3:0]   irqType;
  logic [5:0]   dmaChan;

  always #10 clk = ~clk;

  ldev_cfg_regs uut (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .idxIn(idxIn), .dataWe(dataWe),
    .dataIn(dataIn), .dataOut(dataOut), .memBase(memBase), .memLimit(memLimit),
    .memWide(memWide), .ioBase(ioBase), .irqLevel(irqLevel), .irqType(irqType),
    .dmaChan(dmaChan)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFail = 0;
  logic  sampleReq = 1'b0;
  bit    finished = 1'b0;

  always @(negedge clk) begin
    if (sampleReq && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (dataOut !== it.exp) begin
        nFail++;
        $display("FAIL %s: dataOut=%h expected %h", it.tag, dataOut, it.exp);
      end
    end
  end

  task automatic setIdx(input logic [7:0] i);
    @(posedge clk); #1 idxWe = 1'b1; idxIn = i;
    @(posedge clk); #1 idxWe = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] d);
    setIdx(i);
    @(posedge clk); #1 dataWe = 1'b1; dataIn = d;
    @(posedge clk); #1 dataWe = 1'b0;
  endtask

  task automatic expRead(input logic [7:0] i, input logic [7:0] e, input string tag);
    item_t it;
    setIdx(i);
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    sampleReq = 1'b1;
    @(posedge clk); #1 sampleReq = 1'b0;
  endtask

  task automatic checkVal(input logic [127:0] act, input logic [127:0] e, input string tag);
    nChecks++;
    if (act !== e) begin
      nFail++;
      $display("FAIL %s: actual=%h expected %h", tag, act, e);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [63:0]  snapMem;
    logic [127:0] snapIo;
    logic [5:0]   snapDma;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R3 reset values
    expRead(8'h40, 8'h00, "R3 mem base reset");
    expRead(8'h42, 8'h01, "R3 mem control reset");
    expRead(8'h74, 8'h04, "R3 dma0 reset");
    expRead(8'h70, 8'h00, "R3 irq level reset");
    checkVal(128'(dmaChan), 128'(6'b100_100), "R3 dmaChan reset");
    checkVal(128'(memBase), 128'h0, "R3 memBase reset");

    // R4 memory window 0 and window 2
    wrReg(8'h40, 8'h10); wrReg(8'h41, 8'h00);
    wrReg(8'h43, 8'h11); wrReg(8'h44, 8'h00);
    expRead(8'h40, 8'h10, "R4 base hi");
    expRead(8'h43, 8'h11, "R4 limit hi");
    checkVal(128'(memBase[15:0]), 128'h1000, "R11 memBase window0");
    checkVal(128'(memLimit[15:0]), 128'h1100, "R11 memLimit window0");
    wrReg(8'h50, 8'hAB);
    expRead(8'h50, 8'hAB, "R4 window2 base hi");
    checkVal(128'(memBase[47:32]), 128'hAB00, "R11 memBase window2");
    wrReg(8'h58, 8'h55);
    expRead(8'h58, 8'h00, "R4 absent window3");
    checkVal(128'(memBase[63:48]), 128'h0, "R4 absent window3 output");
    wrReg(8'h45, 8'h77);
    expRead(8'h45, 8'h00, "R4 gap offset");

    // R5 memory control
    wrReg(8'h42, 8'hFF);
    expRead(8'h42, 8'h03, "R5 control all ones");
    checkVal(128'(memWide), 128'h1, "R5 memWide set");
    wrReg(8'h42, 8'h00);
    expRead(8'h42, 8'h01, "R5 control cleared, bit0 read-only");

    // R6 I/O bases
    wrReg(8'h60, 8'hFF); wrReg(8'h61, 8'h34);
    expRead(8'h60, 8'h03, "R6 io hi masked");
    expRead(8'h61, 8'h34, "R6 io lo");
    checkVal(128'(ioBase[15:0]), 128'h0334, "R11 ioBase slot0");
    wrReg(8'h6A, 8'h02);
    expRead(8'h6A, 8'h02, "R6 io slot5 hi");
    wrReg(8'h6C, 8'h01);
    expRead(8'h6C, 8'h00, "R6 absent io slot6");
    checkVal(128'(ioBase[111:96]), 128'h0, "R6 absent io output");

    // R7 interrupts
    wrReg(8'h70, 8'hFB);
    expRead(8'h70, 8'h0B, "R7 irq level0");
    checkVal(128'(irqLevel[3:0]), 128'hB, "R7 irqLevel out");
    wrReg(8'h73, 8'hFF);
    expRead(8'h73, 8'h03, "R7 irq type1");
    checkVal(128'(irqType[3:2]), 128'h3, "R7 irqType out");

    // R8 DMA
    wrReg(8'h74, 8'hFD);
    expRead(8'h74, 8'h05, "R8 dma0");
    checkVal(128'(dmaChan[2:0]), 128'h5, "R8 dmaChan0 out");
    wrReg(8'h75, 8'h01);
    expRead(8'h75, 8'h04, "R8 absent dma1");
    checkVal(128'(dmaChan[5:3]), 128'h4, "R8 absent dma1 output");

    // R9 reserved indices
    snapMem = memBase; snapIo = ioBase; snapDma = dmaChan;
    wrReg(8'h20, 8'h5A); expRead(8'h20, 8'h00, "R9 low reserved");
    wrReg(8'h80, 8'h5A); expRead(8'h80, 8'h00, "R9 high reserved");
    wrReg(8'hFF, 8'h5A); expRead(8'hFF, 8'h00, "R9 index FF");
    checkVal(128'(memBase), 128'(snapMem), "R9 memBase untouched");
    checkVal(ioBase, snapIo, "R9 ioBase untouched");
    checkVal(128'(dmaChan), 128'(snapDma), "R9 dmaChan untouched");

    // R10 vendor scratch
    wrReg(8'hF0, 8'hA5); wrReg(8'hFE, 8'h3C);
    expRead(8'hF0, 8'hA5, "R10 vendor first");
    expRead(8'hFE, 8'h3C, "R10 vendor last");
    expRead(8'hF7, 8'h00, "R10 vendor unwritten");

    // R2 same-edge index and data write goes to the old index
    setIdx(8'h41);
    @(posedge clk); #1 idxWe = 1'b1; idxIn = 8'h50; dataWe = 1'b1; dataIn = 8'h9C;
    @(posedge clk); #1 idxWe = 1'b0; dataWe = 1'b0;
    expRead(8'h41, 8'h9C, "R2 write used old index");
    expRead(8'h50, 8'hAB, "R2 new index untouched");
    checkVal(128'(memBase[15:0]), 128'h109C, "R2 memBase after same-edge write");

    // R1 index change alone switches the read
    setIdx(8'h74);
    expRead(8'h40, 8'h10, "R1 read follows index");

    repeat (2) @(posedge clk);
    report();
  end

endmodule